// File: doc/BRIEF.md
# Parallel Display Bus Inversion Encoder

This block sits between a pixel data source and a parallel display data bus. Each accepted input word is put on the bus either as it is or bitwise inverted, and a separate flag line tells the receiving driver which of the two it is getting. The receiver undoes the inversion whenever the flag is high.

Two control inputs select the policy. With the forced control set, every word goes out inverted. With the automatic control set, the encoder compares the new word with the word currently on the bus. It inverts the new word when more lines would change than stay the same, so that no transfer toggles more than half of the data lines. This lowers switching power and radiated noise. The bus width is a parameter. Widths of 8 and 12 bits are the intended uses.

Top module: `bus_invert_encoder`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `bus_word` to all zeros and `bus_flag` to 0.
- R2: With `force_inv`=0 and `auto_inv`=0, an accepted word appears unchanged on `bus_word` and `bus_flag` is 0.
- R3: With `force_inv`=1, an accepted word appears bitwise inverted on `bus_word` and `bus_flag` is 1.
- R4: With `auto_inv`=1 and `force_inv`=0, let c be the number of ones in (input word XOR current `bus_word`), where `bus_word` is the value actually driven, after any inversion. The word is inverted, with `bus_flag`=1, exactly when c > W-c. Otherwise it passes unchanged with `bus_flag`=0.
- R5: The automatic threshold is 5 or more changed bits at W=8 and 7 or more at W=12. A tie (4 of 8, 6 of 12) does not invert.
- R6: With both controls at 1, forced inversion applies and the automatic decision is ignored.
- R7: `bus_word` and `bus_flag` update together, one clock edge after the edge at which `in_valid` is 1. While `in_valid` is 0 they hold their values, whatever the other inputs do.
- R8: After every accepted word, `bus_flag` is 1 exactly when `bus_word` equals the inverse of that word, and 0 exactly when it equals the word itself.
- R9: In automatic mode (without force), no accepted transfer changes more than W/2 bits of `bus_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_word | input | W | Input data word |
| in_valid | input | 1 | Input word is accepted at this edge |
| force_inv | input | 1 | Invert every accepted word |
| auto_inv | input | 1 | Invert accepted words to minimise toggles |
| bus_word | output | W | Registered data bus |
| bus_flag | output | 1 | High when bus_word holds inverted data |

## Verification
The bench runs an 8-bit and a 12-bit instance side by side. From a known bus value it sends words that differ in exactly W/2 bits and in W/2+1 bits, which pins down whether the threshold is strict and where it sits for each width. A chain of automatic transfers, with some words landing on an already inverted bus, shows whether the comparison uses the driven value or the raw previous input. Pass-through, forced, both-set and idle cycles that carry changing data tell apart the mode priority and the hold behaviour.

// File: rtl/bus_inv_pkg.sv
package bus_inv_pkg;

   typedef enum logic [1:0] {
      MODE_PASS  = 2'd0,
      MODE_AUTO  = 2'd1,
      MODE_FORCE = 2'd2
   } inv_mode_e;

endpackage

// File: rtl/inv_mode_sel.sv
module inv_mode_sel
   import bus_inv_pkg::*;
(
   input  logic      force_inv,
   input  logic      auto_inv,
   output inv_mode_e mode
);

   // forced inversion outranks the automatic policy
   always_comb begin
      if (force_inv)     mode = MODE_FORCE;
      else if (auto_inv) mode = MODE_AUTO;
      else               mode = MODE_PASS;
   end

endmodule

// File: rtl/inv_popcount.sv
module inv_popcount #(
   parameter int W  = 8,
   parameter int G  = 4,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  bits,
   output logic [CW-1:0] count
);

   generate
      if (W < 1) begin : g_bad_w
         $error("inv_popcount: W must be at least 1");
      end
      if (G < 0) begin : g_bad_g
         $error("inv_popcount: G must not be negative");
      end

      if (G <= 1 || G >= W) begin : g_flat
         always_comb begin
            count = '0;
            for (int i = 0; i < W; i++)
               count = count + CW'(bits[i]);
         end
      end else begin : g_grouped
         localparam int NG = (W + G - 1) / G;
         localparam int PW = NG * G;
         logic [PW-1:0]    padded;
         logic [NG*CW-1:0] parts;

         assign padded = PW'(bits);

         for (genvar g = 0; g < NG; g++) begin : g_part
            logic [CW-1:0] cnt;
            always_comb begin
               cnt = '0;
               for (int i = 0; i < G; i++)
                  cnt = cnt + CW'(padded[g*G + i]);
            end
            assign parts[g*CW +: CW] = cnt;
         end

         always_comb begin
            count = '0;
            for (int g = 0; g < NG; g++)
               count = count + parts[g*CW +: CW];
         end
      end
   endgenerate

endmodule

// File: rtl/inv_decide.sv
module inv_decide
   import bus_inv_pkg::*;
#(
   parameter int W  = 8,
   parameter int CW = $clog2(W + 1)
) (
   input  inv_mode_e     mode,
   input  logic [CW-1:0] changed,
   output logic          invert
);

   // strict majority of changed lines: changed > W - changed
   localparam int HALF = W / 2;

   logic majority;
   assign majority = (int'(changed) > HALF);

   always_comb begin
      case (mode)
         MODE_FORCE: invert = 1'b1;
         MODE_AUTO:  invert = majority;
         default:    invert = 1'b0;
      endcase
   end

endmodule

// File: rtl/bus_invert_encoder.sv
module bus_invert_encoder
   import bus_inv_pkg::*;
#(
   parameter int W         = 8,
   parameter int POP_GROUP = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] in_word,
   input  logic         in_valid,
   input  logic         force_inv,
   input  logic         auto_inv,
   output logic [W-1:0] bus_word,
   output logic         bus_flag
);

   localparam int CW = $clog2(W + 1);

   generate
      if (W < 2) begin : g_bad_width
         $error("bus_invert_encoder: W must be at least 2");
      end
   endgenerate

   inv_mode_e     mode;
   logic [W-1:0]  toggles;
   logic [CW-1:0] changed;
   logic          invert;

   inv_mode_sel u_mode (
      .force_inv (force_inv),
      .auto_inv  (auto_inv),
      .mode      (mode)
   );

   // compare against the value really on the bus
   assign toggles = in_word ^ bus_word;

   inv_popcount #(.W(W), .G(POP_GROUP), .CW(CW)) u_pop (
      .bits  (toggles),
      .count (changed)
   );

   inv_decide #(.W(W), .CW(CW)) u_dec (
      .mode    (mode),
      .changed (changed),
      .invert  (invert)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         bus_word <= '0;
         bus_flag <= 1'b0;
      end else if (in_valid) begin
         bus_word <= invert ? ~in_word : in_word;
         bus_flag <= invert;
      end
   end

   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (bus_word == '0 && !bus_flag));

   // R2
   pass_through_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !force_inv && !auto_inv) |=>
         (!bus_flag && bus_word == $past(in_word)));

   // R3
   forced_invert_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && force_inv) |=>
         (bus_flag && bus_word == ~$past(in_word)));

   // R7
   hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(bus_word) && $stable(bus_flag)));

   // R8
   flag_meaning_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (bus_flag ? (bus_word == ~$past(in_word))
                             : (bus_word ==  $past(in_word))));

   // R9
   toggle_bound_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && auto_inv && !force_inv) |=>
         ($countones(bus_word ^ $past(bus_word)) <= W / 2));

endmodule

// File: tb/bus_invert_encoder_test.sv
module bus_invert_encoder_test;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid, force_inv, auto_inv;
   logic [7:0]  d8;
   logic [11:0] d12;
   logic [7:0]  bus8;
   logic [11:0] bus12;
   logic        flag8, flag12;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // bench model state
   logic [7:0]  m8_bus;
   logic [11:0] m12_bus;
   logic        m8_flag, m12_flag;

   always #10 clk = ~clk;

   bus_invert_encoder #(.W(8)) uut (
      .clk(clk), .rst(rst), .in_word(d8), .in_valid(in_valid),
      .force_inv(force_inv), .auto_inv(auto_inv),
      .bus_word(bus8), .bus_flag(flag8)
   );

   bus_invert_encoder #(.W(12), .POP_GROUP(0)) uut12 (
      .clk(clk), .rst(rst), .in_word(d12), .in_valid(in_valid),
      .force_inv(force_inv), .auto_inv(auto_inv),
      .bus_word(bus12), .bus_flag(flag12)
   );

   task automatic check8(input logic [7:0] eb, input logic ef, input string req);
      n_tests++;
      if (bus8 !== eb || flag8 !== ef) begin
         n_fail++;
         $display("FAIL %s W=8: got bus=%h flag=%b, expected bus=%h flag=%b",
                  req, bus8, flag8, eb, ef);
      end
   endtask

   task automatic check12(input logic [11:0] eb, input logic ef, input string req);
      n_tests++;
      if (bus12 !== eb || flag12 !== ef) begin
         n_fail++;
         $display("FAIL %s W=12: got bus=%h flag=%b, expected bus=%h flag=%b",
                  req, bus12, flag12, eb, ef);
      end
   endtask

   // one cycle: drive on falling edge, let the rising edge pass, compare at next falling edge
   task automatic xfer(input logic [7:0] a8, input logic [11:0] a12,
                       input logic v, input logic f, input logic a, input string req);
      int c8, c12;
      logic i8, i12;
      d8 = a8; d12 = a12; in_valid = v; force_inv = f; auto_inv = a;
      c8  = $countones(a8 ^ m8_bus);
      c12 = $countones(a12 ^ m12_bus);
      i8  = f | (a & (c8  > 8  - c8));
      i12 = f | (a & (c12 > 12 - c12));
      if (v) begin
         m8_bus  = i8  ? ~a8  : a8;   m8_flag  = i8;
         m12_bus = i12 ? ~a12 : a12;  m12_flag = i12;
      end
      @(negedge clk);
      check8(m8_bus, m8_flag, req);
      check12(m12_bus, m12_flag, req);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      m8_bus = '0; m12_bus = '0; m8_flag = 1'b0; m12_flag = 1'b0;
      check8(8'h00, 1'b0, "R1");
      check12(12'h000, 1'b0, "R1");
      rst = 1'b0;
   endtask

   task automatic test_pass();
      for (int i = 0; i < 6; i++)
         xfer(8'(i * 37 + 5), 12'(i * 611 + 9), 1'b1, 1'b0, 1'b0, "R2");
      xfer(8'hA5, 12'h5A3, 1'b1, 1'b0, 1'b0, "R2");
      check8(8'hA5, 1'b0, "R2");
      check12(12'h5A3, 1'b0, "R2");
   endtask

   task automatic test_force();
      xfer(8'h3C, 12'h0F0, 1'b1, 1'b1, 1'b0, "R3");
      check8(8'hC3, 1'b1, "R3");
      check12(12'hF0F, 1'b1, "R3");
      xfer(8'h00, 12'h000, 1'b1, 1'b1, 1'b0, "R3");
      check8(8'hFF, 1'b1, "R3");
   endtask

   task automatic test_both();
      // from all-zero bus, 8'h01 would not auto-invert; force must win
      do_reset();
      xfer(8'h01, 12'h001, 1'b1, 1'b1, 1'b1, "R6");
      check8(8'hFE, 1'b1, "R6");
      check12(12'hFFE, 1'b1, "R6");
   endtask

   task automatic test_threshold();
      do_reset();
      // tie: 4 of 8 and 6 of 12 changed from zero -> no inversion
      xfer(8'h0F, 12'h03F, 1'b1, 1'b0, 1'b1, "R5");
      check8(8'h0F, 1'b0, "R5");
      check12(12'h03F, 1'b0, "R5");
      // 5 of 8 and 7 of 12 changed -> inversion
      xfer(8'h0F ^ 8'h1F, 12'h03F ^ 12'h07F, 1'b1, 1'b0, 1'b1, "R5");
      check8(8'hEF, 1'b1, "R5");
      check12(12'hFBF, 1'b1, "R5");
   endtask

   task automatic test_auto_chain();
      // bus now holds inverted data; comparison must use that driven value
      // bus8=EF: 8'h10 differs in all 8 -> send EF again (flag 1, zero toggles)
      xfer(8'h10, 12'h040, 1'b1, 1'b0, 1'b1, "R4");
      check8(8'hEF, 1'b1, "R4");
      check12(12'hFBF, 1'b1, "R4");
      for (int i = 0; i < 12; i++)
         xfer(8'(i * 91 + 17), 12'(i * 1237 + 71), 1'b1, 1'b0, 1'b1, "R4 R8 R9");
   endtask

   task automatic test_hold();
      logic [7:0]  h8;
      logic [11:0] h12;
      h8 = m8_bus; h12 = m12_bus;
      for (int i = 0; i < 4; i++)
         xfer(8'(~h8 + 8'(i)), 12'(~h12 + 12'(i)), 1'b0, 1'(i & 1), 1'(i >> 1), "R7");
      check8(h8, m8_flag, "R7");
      check12(h12, m12_flag, "R7");
   endtask

   initial begin
      rst = 1'b1; in_valid = 1'b0; force_inv = 1'b0; auto_inv = 1'b0;
      d8 = '0; d12 = '0;
      m8_bus = '0; m12_bus = '0; m8_flag = 1'b0; m12_flag = 1'b0;
      @(negedge clk);
      do_reset();
      test_pass();
      test_force();
      test_both();
      test_threshold();
      test_auto_chain();
      test_hold();
      // reset in the middle of traffic
      xfer(8'h77, 12'h777, 1'b1, 1'b1, 1'b0, "R3");
      do_reset();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule